// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

The controller gathers thirteen request lines, numbered 1 to 13, into a pending register and gates them with a mask. Each source owns an 8-bit control register that sets whether the source uses an autovector, which interrupt level it raises, and its priority inside that level. Among the sources that are pending and not masked, the one with the largest combined level-and-priority key wins, and the controller drives the winner's 3-bit level and an 8-bit vector toward the processor.

A winner with autovectoring enabled gets the vector 24 plus its level. Otherwise, the vector comes from a per-source vector register: source 8 reads a software vector register, and sources 12 and 13 each read a register of their own. Any other source falls back to 0x0F. A key that decodes to level 0 never produces an interrupt. Software programs the block through a simple register port. Writes take effect at the clock edge. Reads return data combinationally from the read address.

Top module: `prio_irq_ctrl`

## Requirements
- R1: At every clock edge, the pending register captures request lines 1 to 13. Its contents read back at address 0x3A, with source i in bit i and bit 0 and bits 15:14 reading 0.
- R2: The mask register sits at address 0x36, and source i uses bit i. A 1 blocks the source. A masked source never takes part in selection, and with no unmasked pending source, level and vector are both 0.
- R3: The winner is the active source whose control bits 4:0 hold the largest value. When two keys are equal, the lower-numbered source wins.
- R4: If the winning key is below 4, meaning its level field is 0, the controller presents level 0 and vector 0.
- R5: The presented level is bits 4:2 of the winner's control register. When bit 7 of that register is 1, the vector is 24 plus the level.
- R6: Without autovectoring, source 8 takes its vector from the software vector register at 0x40. Source 12 uses the register at 0x44 and source 13 the register at 0x46, all three read back in bits 7:0 and reset to 0x0F. Every other source yields 0x0F.
- R7: On reset, the mask reads 0x3FFE, and the level and vector outputs are 0. The control registers reset as follows: sources 1 to 7 to 4 times the source number, source 8 to 0x1C, sources 9 to 11 to 0x80, and sources 12 and 13 to 0x00.
- R8: The control register for source i lives at byte address 0x13 plus i, covering 0x14 to 0x20. A write stores bits 7:0 of the write data, and a read returns the stored byte in bits 7:0.
- R9: The pending register is read-only. A write to 0x3A changes neither its readback nor the outputs.
- R10: Level and vector are registered outputs. A register write or a pending change at one clock edge shows at the outputs on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 13 | Request lines, bit i is source i (range 13:1) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cpu_level | output | 3 | Presented interrupt level, 0 when none |
| cpu_vector | output | 8 | Presented interrupt vector, 0 when none |

## Verification
Selection is driven by request sets that pit unequal levels against each other, keys that differ only in the priority bits, and exactly equal keys, so that a largest-key search, a level-only compare and a tie toward the higher number each give a different winner. The vector path is tried with autovectored winners and with non-autovectored winners from sources 8, 12 and 13 and from an ordinary source, so every vector origin produces a distinct value. Masking a lone winner, keys below 4, and a write to the pending address separate a suppressed or ignored case from one that leaks through. A check in the cycle right after a control write tells a registered output from a combinational one.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NUM_SRC = 13;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 8;
    localparam int SRC_W   = $clog2(NUM_SRC + 1);

    localparam logic [ADDR_W-1:0] ADDR_CTRL_BASE = 8'h14;
    localparam logic [ADDR_W-1:0] ADDR_MASK      = 8'h36;
    localparam logic [ADDR_W-1:0] ADDR_PEND      = 8'h3A;
    localparam logic [ADDR_W-1:0] ADDR_SWVEC     = 8'h40;
    localparam logic [ADDR_W-1:0] ADDR_VEC_A     = 8'h44;
    localparam logic [ADDR_W-1:0] ADDR_VEC_B     = 8'h46;

    localparam int SRC_SW = 8;
    localparam int SRC_A  = 12;
    localparam int SRC_B  = 13;

    localparam logic [7:0] VEC_DEFAULT  = 8'h0F;
    localparam logic [7:0] AUTOVEC_BASE = 8'd24;
    localparam logic [4:0] KEY_MIN      = 5'd4;

    typedef struct packed {
        logic       autovec;
        logic [1:0] rsvd;
        logic [2:0] level;
        logic [1:0] prio;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
        ctrl_t            ctrl;
    } win_t;

    function automatic logic [4:0] key_of(input ctrl_t c);
        return {c.level, c.prio};
    endfunction

    function automatic ctrl_t ctrl_reset(input int idx);
        logic [7:0] v;
        if (idx <= 7)       v = 8'(idx * 4);
        else if (idx == 8)  v = 8'h1C;
        else if (idx <= 11) v = 8'h80;
        else                v = 8'h00;
        return ctrl_t'(v);
    endfunction

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC:1]    irq_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_SRC:1]    pend,
    output logic [N_SRC:1]    mask,
    output ctrl_t             ctrl [1:N_SRC],
    output logic [7:0]        sw_vec,
    output logic [7:0]        vec_a,
    output logic [7:0]        vec_b
);

    logic unused_wdata;
    assign unused_wdata = ^{wr_data[DATA_W-1:N_SRC+1], wr_data[0]};

    // Pending bits follow the request lines; no bus write path exists.
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= irq_req;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '1;
        else if (wr_en && wr_addr == ADDR_MASK)
            mask <= wr_data[N_SRC:1];
    end

    for (genvar g = 1; g <= N_SRC; g++) begin : g_ctrl
        localparam logic [ADDR_W-1:0] CADDR = ADDR_W'(int'(ADDR_CTRL_BASE) + g - 1);
        always_ff @(posedge clk) begin
            if (rst)
                ctrl[g] <= ctrl_reset(g);
            else if (wr_en && wr_addr == CADDR)
                ctrl[g] <= ctrl_t'(wr_data[7:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_vec <= VEC_DEFAULT;
            vec_a  <= VEC_DEFAULT;
            vec_b  <= VEC_DEFAULT;
        end else if (wr_en) begin
            if (wr_addr == ADDR_SWVEC) sw_vec <= wr_data[7:0];
            if (wr_addr == ADDR_VEC_A) vec_a  <= wr_data[7:0];
            if (wr_addr == ADDR_VEC_B) vec_b  <= wr_data[7:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_MASK) rd_data[N_SRC:1] = mask;
        if (rd_addr == ADDR_PEND) rd_data[N_SRC:1] = pend;
        if (rd_addr == ADDR_SWVEC) rd_data[7:0] = sw_vec;
        if (rd_addr == ADDR_VEC_A) rd_data[7:0] = vec_a;
        if (rd_addr == ADDR_VEC_B) rd_data[7:0] = vec_b;
        for (int i = 1; i <= N_SRC; i++) begin
            if (rd_addr == ADDR_W'(int'(ADDR_CTRL_BASE) + i - 1))
                rd_data[7:0] = ctrl[i];
        end
    end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [N_SRC:1] active,
    input  ctrl_t          ctrl [1:N_SRC],
    output win_t           win
);

    logic [4:0]       best_key;
    logic [SRC_W-1:0] best_src;
    ctrl_t            best_ctrl;

    // Strict greater-than keeps the lower-numbered source on equal keys.
    always_comb begin
        best_key  = '0;
        best_src  = '0;
        best_ctrl = '0;
        for (int i = 1; i <= N_SRC; i++) begin
            if (active[i] && key_of(ctrl[i]) > best_key) begin
                best_key  = key_of(ctrl[i]);
                best_src  = SRC_W'(i);
                best_ctrl = ctrl[i];
            end
        end
        win.valid = (best_key >= KEY_MIN);
        win.src   = best_src;
        win.ctrl  = best_ctrl;
    end

endmodule

// File: rtl/pic_vector.sv
module pic_vector
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  win_t       win,
    input  logic [7:0] sw_vec,
    input  logic [7:0] vec_a,
    input  logic [7:0] vec_b,
    output logic [2:0] cpu_level,
    output logic [7:0] cpu_vector
);

    logic [2:0] lvl_d;
    logic [7:0] vec_d;
    logic       unused_ctrl;

    assign unused_ctrl = ^{win.ctrl.rsvd, win.ctrl.prio};

    always_comb begin
        lvl_d = '0;
        vec_d = '0;
        if (win.valid) begin
            lvl_d = win.ctrl.level;
            if (win.ctrl.autovec)
                vec_d = AUTOVEC_BASE + 8'(win.ctrl.level);
            else if (win.src == SRC_W'(SRC_SW))
                vec_d = sw_vec;
            else if (win.src == SRC_W'(SRC_A))
                vec_d = vec_a;
            else if (win.src == SRC_W'(SRC_B))
                vec_d = vec_b;
            else
                vec_d = VEC_DEFAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_level  <= '0;
            cpu_vector <= '0;
        end else begin
            cpu_level  <= lvl_d;
            cpu_vector <= vec_d;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC:1]    irq_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        cpu_level,
    output logic [7:0]        cpu_vector
);

    logic [N_SRC:1] pend;
    logic [N_SRC:1] mask;
    logic [N_SRC:1] active;
    ctrl_t          ctrl [1:N_SRC];
    logic [7:0]     sw_vec;
    logic [7:0]     vec_a;
    logic [7:0]     vec_b;
    win_t           win;

    pic_regs #(.N_SRC(N_SRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .irq_req (irq_req),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pend    (pend),
        .mask    (mask),
        .ctrl    (ctrl),
        .sw_vec  (sw_vec),
        .vec_a   (vec_a),
        .vec_b   (vec_b)
    );

    assign active = pend & ~mask;

    pic_arbiter #(.N_SRC(N_SRC)) u_arb (
        .active (active),
        .ctrl   (ctrl),
        .win    (win)
    );

    pic_vector u_vec (
        .clk        (clk),
        .rst        (rst),
        .win        (win),
        .sw_vec     (sw_vec),
        .vec_a      (vec_a),
        .vec_b      (vec_b),
        .cpu_level  (cpu_level),
        .cpu_vector (cpu_vector)
    );

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int N_SRC = 13
) (
    input logic           clk,
    input logic           rst,
    input logic [N_SRC:1] irq_req,
    input logic           wr_en,
    input logic [N_SRC:1] pend,
    input logic [N_SRC:1] mask,
    input logic [2:0]     cpu_level,
    input logic [7:0]     cpu_vector
);

    a_r1_pend_tracks_req: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pend == $past(irq_req));

    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~mask) == '0) |=> (cpu_level == 3'd0 && cpu_vector == 8'd0));

    a_r4_no_level_no_vector: assert property (@(posedge clk) disable iff (rst)
        (cpu_level == 3'd0) |-> (cpu_vector == 8'd0));

    a_r10_quiet_inputs_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && $stable(pend)) |=> ($stable(cpu_level) && $stable(cpu_vector)));

endmodule

bind prio_irq_ctrl pic_checker #(.N_SRC(N_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .wr_en      (wr_en),
    .pend       (pend),
    .mask       (mask),
    .cpu_level  (cpu_level),
    .cpu_vector (cpu_vector)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:1] irq_req = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  cpu_level;
    logic [7:0]  cpu_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    prio_irq_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .irq_req    (irq_req),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .cpu_level  (cpu_level),
        .cpu_vector (cpu_vector)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input int exp);
        rd_addr = a;
        #1;
        check(tag, int'(rd_data), exp);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic out_check(input string tag, input int lvl, input int vec);
        check({tag, " level"}, int'(cpu_level), lvl);
        check({tag, " vector"}, int'(cpu_vector), vec);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rd_check("R7 mask reset", 8'h36, 16'h3FFE);
        rd_check("R7 R8 ctrl1 reset", 8'h14, 8'h04);
        rd_check("R7 ctrl7 reset", 8'h1A, 8'h1C);
        rd_check("R7 ctrl8 reset", 8'h1B, 8'h1C);
        rd_check("R7 ctrl10 reset", 8'h1D, 8'h80);
        rd_check("R7 ctrl13 reset", 8'h20, 8'h00);
        rd_check("R6 R7 swvec reset", 8'h40, 8'h0F);
        rd_check("R6 R7 veca reset", 8'h44, 8'h0F);
        out_check("R7 outputs reset", 0, 0);
    endtask

    task automatic t_mask();
        @(negedge clk);
        irq_req = 13'b0;
        irq_req[3] = 1'b1;
        settle();
        rd_check("R1 pending bit3", 8'h3A, 16'h0008);
        out_check("R2 all masked", 0, 0);
        wr(8'h36, 16'h0000);
        settle();
        out_check("R2 R6 unmasked src3", 3, 8'h0F);
    endtask

    task automatic t_auto_latency();
        wr(8'h16, 16'h0095);
        out_check("R10 old value one cycle", 3, 8'h0F);
        @(negedge clk);
        out_check("R5 R10 autovector src3", 5, 29);
        rd_check("R8 ctrl3 readback", 8'h16, 8'h95);
    endtask

    task automatic t_prio();
        wr(8'h17, 16'h009E);
        wr(8'h19, 16'h001D);
        @(negedge clk);
        irq_req[4] = 1'b1;
        irq_req[6] = 1'b1;
        settle();
        out_check("R3 prio bits decide", 7, 31);
        wr(8'h19, 16'h001F);
        settle();
        out_check("R3 higher prio src6", 7, 8'h0F);
    endtask

    task automatic t_tie();
        wr(8'h18, 16'h0019);
        wr(8'h1F, 16'h0019);
        wr(8'h44, 16'h0055);
        @(negedge clk);
        irq_req = 13'b0;
        irq_req[5]  = 1'b1;
        irq_req[12] = 1'b1;
        settle();
        out_check("R3 tie lower wins", 6, 8'h0F);
        @(negedge clk);
        irq_req[5] = 1'b0;
        settle();
        out_check("R6 src12 vector reg", 6, 8'h55);
        wr(8'h36, 16'h1000);
        settle();
        out_check("R2 mask lone winner", 0, 0);
    endtask

    task automatic t_low_key();
        wr(8'h36, 16'h0000);
        wr(8'h20, 16'h0003);
        wr(8'h46, 16'h0066);
        @(negedge clk);
        irq_req = 13'b0;
        irq_req[13] = 1'b1;
        settle();
        out_check("R4 key below four", 0, 0);
        wr(8'h20, 16'h0004);
        settle();
        out_check("R6 src13 vector reg", 1, 8'h66);
        wr(8'h40, 16'h0040);
        @(negedge clk);
        irq_req[8] = 1'b1;
        settle();
        out_check("R6 src8 software vector", 7, 8'h40);
    endtask

    task automatic t_pend_ro();
        wr(8'h3A, 16'hFFFF);
        settle();
        rd_check("R9 pending unchanged", 8'h3A, 16'h2100);
        out_check("R9 outputs unchanged", 7, 8'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mask();
        t_auto_latency();
        t_prio();
        t_tie();
        t_low_key();
        t_pend_ro();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule